// File: doc/BRIEF.md
# Cache Line Write-Back Buffer

This block parks one dirty cache line that the replacement logic has chosen to evict. The line refill can then use the memory bus first, and the old contents reach external memory later. When the cache offers a victim line that is dirty and whose region uses write-back policy, the buffer latches the line's four 32-bit words and its line address, which is the physical address with the four byte-offset bits removed. It then writes the words out one at a time through a request/acknowledge write port.

Any line refill that is allowed to run takes the bus ahead of the drain, and the drain picks up again where it stopped. The cache stays usable while the drain runs. The block gates only two things: a new capture, which must wait while the buffer is occupied, and a refill that targets the buffered line itself, which is held back until that line has reached memory.

Top module: `evict_line_buf`

## Requirements
- R1: After reset `buf_empty` and `cap_ready` are 1 and `mem_req` is 0.
- R2: A capture offer is taken only when `cap_valid`, `cap_wb_mode` and `cap_dirty` are all 1 together with `cap_ready`. An offer missing `cap_wb_mode` or `cap_dirty` leaves `buf_empty` at 1 and `mem_req` at 0.
- R3: `cap_ready` is 0 while the buffer holds undrained data. An offer made during that time is not taken and does not change the words or the address being drained.
- R4: The drain writes word 0, then 1, 2 and 3. Word n sits in `cap_line` bits [32n+31:32n] and is written to byte address {`cap_tag`, 4'h0} + 4n.
- R5: From the cycle after a capture, `mem_req` is 1 unless R6 blocks it. `mem_addr` and `mem_data` hold steady until a cycle in which `mem_ack` is 1 and `mem_req` is 1.
- R6: In any cycle where `refill_go` is 1, `mem_req` is 0.
- R7: While the buffer holds a line whose tag equals `refill_tag`, `refill_go` is 0 and `buf_hit` is 1. Once the buffer has drained, `refill_go` follows `refill_req`.
- R8: `buf_empty` and `cap_ready` become 1 in the cycle after the edge that acknowledges word 3.
- R9: A refill whose tag differs from the buffered line, or any refill while the buffer is empty, gets `refill_go` = `refill_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Cache offers a victim line |
| cap_wb_mode | input | 1 | Victim region uses write-back policy |
| cap_dirty | input | 1 | Victim line is modified |
| cap_tag | input | 28 | Victim physical address bits [31:4] |
| cap_line | input | 128 | Victim words, word n at bits [32n+31:32n] |
| cap_ready | output | 1 | Buffer can take a line |
| refill_req | input | 1 | Refill engine wants the bus |
| refill_tag | input | 28 | Line address of the refill |
| refill_go | output | 1 | Refill may use the bus now |
| mem_req | output | 1 | Write request to memory |
| mem_addr | output | 32 | Byte address of the word being written |
| mem_data | output | 32 | Word being written |
| mem_ack | input | 1 | Memory accepts the word at this edge |
| buf_empty | output | 1 | No line is held |
| buf_hit | output | 1 | The held line matches `refill_tag` |

## Verification
Three outputs are combinational: `refill_go`, `buf_hit` and `mem_req` react to `refill_req`, `refill_tag` and the held state in the same cycle. The bench therefore drives inputs on the falling edge and checks these outputs 1 ns later. A capture shows up as `buf_empty` = 0 and a raised `mem_req` one edge after the offer. `mem_addr` and `mem_data` move to the next word one edge after an acknowledge, and `buf_empty` returns to 1 one edge after the acknowledge of word 3. The bench keeps a word index of its own that it advances only when it has seen request and acknowledge together before that edge, so every comparison falls in the cycle where the value is due.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  parameter int unsigned EB_ADDR_W = 32;
  parameter int unsigned EB_WORD_W = 32;
  parameter int unsigned EB_WORDS  = 4;

  typedef enum logic [1:0] {
    EB_IDLE  = 2'd0,
    EB_SEND  = 2'd1,
    EB_YIELD = 2'd2
  } eb_state_t;
endpackage

// File: rtl/evbuf_store.sv
module evbuf_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned TAG_W  = 28,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [TAG_W-1:0]        in_tag,
  input  logic [WORD_W*WORDS-1:0] in_line,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORD_W-1:0]       rd_word,
  output logic [TAG_W-1:0]        held_tag
);
  logic [WORD_W-1:0] words_q [WORDS];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          words_q[g] <= '0;
        end else if (load) begin
          words_q[g] <= in_line[g*WORD_W +: WORD_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_tag <= '0;
    end else if (load) begin
      held_tag <= in_tag;
    end
  end

  assign rd_word = words_q[rd_idx];
endmodule

// File: rtl/evbuf_drain.sv
module evbuf_drain
  import evbuf_pkg::*;
#(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             yield_bus,
  input  logic             mem_ack,
  output logic             full,
  output logic [IDX_W-1:0] idx,
  output logic             mem_req,
  output logic             word_done,
  output logic             last_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  eb_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_q;

  assign full      = (state_q != EB_IDLE);
  assign mem_req   = full && !yield_bus;
  assign word_done = mem_req && mem_ack;
  assign last_done = word_done && (idx_q == LAST_IDX);
  assign idx       = idx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EB_IDLE:  if (load) state_d = EB_SEND;
      EB_SEND:  begin
        if (last_done)      state_d = EB_IDLE;
        else if (yield_bus) state_d = EB_YIELD;
      end
      EB_YIELD: if (!yield_bus) state_d = EB_SEND;
      default:  state_d = EB_IDLE;
    endcase
    if (last_done) state_d = EB_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EB_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load)           idx_q <= '0;
      else if (last_done) idx_q <= '0;
      else if (word_done) idx_q <= idx_q + 1'b1;
    end
  end

  a_r8_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !full);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);
endmodule

// File: rtl/evbuf_hazard.sv
module evbuf_hazard #(
  parameter int unsigned TAG_W = 28
) (
  input  logic             full,
  input  logic [TAG_W-1:0] held_tag,
  input  logic             refill_req,
  input  logic [TAG_W-1:0] refill_tag,
  output logic             hit,
  output logic             go
);
  function automatic logic same_line(input logic [TAG_W-1:0] a,
                                     input logic [TAG_W-1:0] b);
    return a == b;
  endfunction

  assign hit = full && same_line(held_tag, refill_tag);
  assign go  = refill_req && !hit;
endmodule

// File: rtl/evict_line_buf.sv
module evict_line_buf
  import evbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = EB_ADDR_W,
  parameter int unsigned WORD_W = EB_WORD_W,
  parameter int unsigned WORDS  = EB_WORDS,
  localparam int unsigned LINE_BYTES = WORDS * WORD_W / 8,
  localparam int unsigned OFFS_W = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W,
  localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_valid,
  input  logic                    cap_wb_mode,
  input  logic                    cap_dirty,
  input  logic [TAG_W-1:0]        cap_tag,
  input  logic [WORD_W*WORDS-1:0] cap_line,
  output logic                    cap_ready,
  input  logic                    refill_req,
  input  logic [TAG_W-1:0]        refill_tag,
  output logic                    refill_go,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_data,
  input  logic                    mem_ack,
  output logic                    buf_empty,
  output logic                    buf_hit
);
  function automatic logic [ADDR_W-1:0] word_byte_addr(
      input logic [TAG_W-1:0] tag, input logic [IDX_W-1:0] n);
    logic [ADDR_W-1:0] base;
    base = {tag, {OFFS_W{1'b0}}};
    return base + ADDR_W'(n) * ADDR_W'(WORD_W / 8);
  endfunction

  logic             cap_fire;
  logic             full;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] held_tag;
  logic             word_done;
  logic             last_done;

  assign cap_ready = !full;
  assign cap_fire  = cap_valid && cap_wb_mode && cap_dirty && cap_ready;
  assign buf_empty = !full;

  evbuf_store #(.WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cap_fire),
    .in_tag   (cap_tag),
    .in_line  (cap_line),
    .rd_idx   (idx),
    .rd_word  (mem_data),
    .held_tag (held_tag)
  );

  evbuf_hazard #(.TAG_W(TAG_W)) i_hazard (
    .full       (full),
    .held_tag   (held_tag),
    .refill_req (refill_req),
    .refill_tag (refill_tag),
    .hit        (buf_hit),
    .go         (refill_go)
  );

  evbuf_drain #(.WORDS(WORDS)) i_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cap_fire),
    .yield_bus (refill_go),
    .mem_ack   (mem_ack),
    .full      (full),
    .idx       (idx),
    .mem_req   (mem_req),
    .word_done (word_done),
    .last_done (last_done)
  );

  assign mem_addr = word_byte_addr(held_tag, idx);

  a_r6_refill_first: assert property (@(posedge clk) disable iff (!rst_n)
    refill_go |-> !mem_req);
  a_r7_no_stale: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit |-> !refill_go);
  a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_data)));
  a_r2_capture_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !(cap_valid && cap_wb_mode && cap_dirty)) |=> buf_empty);
endmodule

// File: tb/test_evict_line_buf.sv
module test_evict_line_buf;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_valid = 1'b0, cap_wb_mode = 1'b0, cap_dirty = 1'b0;
  logic [27:0]  cap_tag = '0;
  logic [127:0] cap_line = '0;
  logic         cap_ready;
  logic         refill_req = 1'b0;
  logic [27:0]  refill_tag = '0;
  logic         refill_go;
  logic         mem_req;
  logic [31:0]  mem_addr, mem_data;
  logic         mem_ack = 1'b0;
  logic         buf_empty, buf_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evict_line_buf i_evict_line_buf (
    .clk(clk), .rst_n(rst_n),
    .cap_valid(cap_valid), .cap_wb_mode(cap_wb_mode), .cap_dirty(cap_dirty),
    .cap_tag(cap_tag), .cap_line(cap_line), .cap_ready(cap_ready),
    .refill_req(refill_req), .refill_tag(refill_tag), .refill_go(refill_go),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .buf_empty(buf_empty), .buf_hit(buf_hit)
  );

  function automatic logic [31:0] exp_addr(input logic [27:0] tag, input int n);
    return {tag, 4'b0000} + 32'(4 * n);
  endfunction

  function automatic logic [31:0] exp_word(input logic [127:0] line, input int n);
    return line[32*n +: 32];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer one line; checks the ready level and the result after the edge.
  task automatic offer(input logic wb, input logic dirty, input logic [27:0] tag,
                       input logic [127:0] line, input bit expect_take);
    @(negedge clk);
    cap_valid = 1'b1; cap_wb_mode = wb; cap_dirty = dirty;
    cap_tag = tag; cap_line = line;
    refill_req = 1'b0; mem_ack = 1'b0;
    #1;
    chk(cap_ready == 1'b1, "R2 ready", 64'(cap_ready), 64'd1);
    @(negedge clk);
    cap_valid = 1'b0;
    #1;
    if (expect_take) begin
      chk(buf_empty == 1'b0, "R5 captured", 64'(buf_empty), 64'd0);
      chk(mem_req == 1'b1, "R5 req after capture", 64'(mem_req), 64'd1);
    end else begin
      chk(buf_empty == 1'b1, "R2 not captured", 64'(buf_empty), 64'd1);
      chk(mem_req == 1'b0, "R2 no request", 64'(mem_req), 64'd0);
    end
  endtask

  // Drain the held line under random acks and random refill traffic.
  task automatic drain(input logic [27:0] tag, input logic [127:0] line,
                       input bool_rand);
    int n = 0;
    int guard = 0;
    while (n < 4 && guard < 2000) begin
      logic exp_go;
      logic exp_hit;
      guard++;
      if (guard > 1) @(negedge clk);
      mem_ack = bool_rand ? 1'($urandom_range(0, 1)) : 1'b1;
      if (bool_rand && $urandom_range(0, 3) == 0) begin
        refill_req = 1'b1;
        refill_tag = ($urandom_range(0, 1) == 0) ? tag : 28'($urandom);
      end else begin
        refill_req = 1'b0;
        refill_tag = 28'($urandom);
      end
      #1;
      exp_hit = (refill_tag == tag);
      exp_go  = refill_req && !exp_hit;
      chk(buf_hit == exp_hit, "R7 hit", 64'(buf_hit), 64'(exp_hit));
      if (exp_hit) chk(refill_go == 1'b0, "R7 match held", 64'(refill_go), 64'(exp_go));
      else         chk(refill_go == exp_go, "R9 refill go", 64'(refill_go), 64'(exp_go));
      chk(mem_req == !exp_go, "R6 yield", 64'(mem_req), 64'(!exp_go));
      chk(buf_empty == 1'b0, "R3 held", 64'(buf_empty), 64'd0);
      chk(cap_ready == 1'b0, "R3 not ready", 64'(cap_ready), 64'd0);
      if (mem_req) begin
        chk(mem_addr == exp_addr(tag, n), "R4 addr", 64'(mem_addr), 64'(exp_addr(tag, n)));
        chk(mem_data == exp_word(line, n), "R4 data", 64'(mem_data), 64'(exp_word(line, n)));
        if (mem_ack) n++;
      end
    end
    if (n < 4) chk(1'b0, "R5 drain stuck", 64'(n), 64'd4);
    @(negedge clk);
    mem_ack = 1'b0;
    refill_req = 1'b1;
    refill_tag = tag;
    #1;
    chk(buf_empty == 1'b1, "R8 empty", 64'(buf_empty), 64'd1);
    chk(cap_ready == 1'b1, "R8 ready", 64'(cap_ready), 64'd1);
    chk(refill_go == 1'b1, "R7 released", 64'(refill_go), 64'd1);
    chk(mem_req == 1'b0, "R8 no request", 64'(mem_req), 64'd0);
    refill_req = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [27:0]  tag_a, tag_b;
    logic [127:0] line_a, line_b;
    void'($urandom(32'h5eed_0427));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(buf_empty == 1'b1, "R1 empty", 64'(buf_empty), 64'd1);
    chk(cap_ready == 1'b1, "R1 ready", 64'(cap_ready), 64'd1);
    chk(mem_req == 1'b0, "R1 no request", 64'(mem_req), 64'd0);

    // R9 refill with empty buffer
    @(negedge clk);
    refill_req = 1'b1; refill_tag = 28'h1234567;
    #1;
    chk(refill_go == 1'b1, "R9 empty go", 64'(refill_go), 64'd1);
    refill_req = 1'b0;

    // R2 rejected offers
    offer(1'b0, 1'b1, 28'h0000abc, {4{32'hdead_beef}}, 1'b0);
    offer(1'b1, 1'b0, 28'h0000abc, {4{32'hdead_beef}}, 1'b0);
    offer(1'b0, 1'b0, 28'h0000abc, {4{32'hdead_beef}}, 1'b0);

    // R4 directed: boundary tags, back-to-back acks
    tag_a = 28'hfffffff;
    line_a = {32'h33333333, 32'h22222222, 32'h11111111, 32'h00000000};
    offer(1'b1, 1'b1, tag_a, line_a, 1'b1);
    drain(tag_a, line_a, 1'b0);
    tag_a = 28'h0000000;
    offer(1'b1, 1'b1, tag_a, line_a, 1'b1);
    drain(tag_a, line_a, 1'b0);

    // R3 offer while full is stalled and leaves the held line intact
    tag_a = 28'h0badcaf; line_a = {32'ha3, 32'ha2, 32'ha1, 32'ha0};
    tag_b = 28'h0c0ffee; line_b = {32'hb3, 32'hb2, 32'hb1, 32'hb0};
    offer(1'b1, 1'b1, tag_a, line_a, 1'b1);
    @(negedge clk);
    refill_req = 1'b1; refill_tag = 28'h7777777;  // keep drain parked
    cap_valid = 1'b1; cap_wb_mode = 1'b1; cap_dirty = 1'b1;
    cap_tag = tag_b; cap_line = line_b;
    #1;
    chk(cap_ready == 1'b0, "R3 stall", 64'(cap_ready), 64'd0);
    @(negedge clk);
    cap_valid = 1'b0;
    refill_req = 1'b0;
    drain(tag_a, line_a, 1'b1);

    // Random traffic
    for (int k = 0; k < 60; k++) begin
      tag_a  = 28'($urandom);
      line_a = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 4) == 0) begin
        offer(1'($urandom_range(0, 1)), 1'b0, tag_a, line_a, 1'b0);
      end else begin
        offer(1'b1, 1'b1, tag_a, line_a, 1'b1);
        drain(tag_a, line_a, 1'b1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule